// File: doc/BRIEF.md
# Lockable Secure-Memory Window Control Registers

This block holds the configuration bytes that steer a secure-memory window: a control byte with open, closed and lock controls plus a fixed base-segment field, an extended byte with the high-window enable, the global window enable and the segment size and enable fields, and a byte for the extended top of the window. Software reaches all three through a byte-wide configuration port with an offset, a byte enable, and a read that returns data one cycle later.

The decoded controls leave the block as plain wires for the address decoders elsewhere in the chip. The open, closed, lock and high-window outputs are gated by the global enable. The lock bit is one-way: the write that sets it also clears the open bit, and from then on the open bit, the lock bit, the high-window enable, the segment size and enable and the extended top ignore writes. Only the full-reset input clears the lock bit again.

Top module: `smram_ctl_regs`

## Requirements
- R1: After full reset every writable bit is 0, so offset 61h reads 8'h02, offsets 62h and 63h read 8'h00, and every control output is 0.
- R2: At offset 61h, bit 6 is open, bit 5 is closed and bit 4 is lock. Bits 2:0 always read 3'b010 and ignore writes. Reserved bits 7 and 3 read 0.
- R3: At offset 62h, bit 7 is the high-window enable, bit 6 is a mono-display flag that is stored and read back with no other effect, bit 3 is the global enable, bits 2:1 are the segment size and bit 0 is the segment enable. Reserved bits 5:4 read 0. Offset 63h holds the 8-bit extended top.
- R4: While the global enable is 0, the outputs open_o, closed_o, lock_o and high_o are 0 whatever the stored bits are. While it is 1, each output equals its stored bit.
- R5: A write that takes the lock bit from 0 to 1 leaves the open bit at 0 after the same clock edge, even if that write also sets bit 6.
- R6: While the lock bit is 1, writes do not change open, lock, high-window enable, segment size, segment enable or extended top. Closed, mono-display and global enable stay writable. The freeze depends only on the stored lock bit.
- R7: A write of 0 to the lock bit has no effect. Only full reset clears it.
- R8: A read request returns the register value on cfg_rdata with cfg_rvalid high in the following cycle. The value is the one held before any write in the same cycle. Unmapped offsets read 8'h00.
- R9: A write with cfg_be low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| full_rst_n | input | 1 | Full reset, active low, asynchronous |
| cfg_wr | input | 1 | Configuration write request |
| cfg_rd | input | 1 | Configuration read request |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_be | input | 1 | Byte enable for writes |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data, one cycle after the request |
| cfg_rvalid | output | 1 | Read data valid |
| open_o | output | 1 | Window forced open (gated by global enable) |
| closed_o | output | 1 | Data access closed (gated by global enable) |
| lock_o | output | 1 | Lock active (gated by global enable) |
| glob_en_o | output | 1 | Global window enable |
| high_en_o | output | 1 | High window enabled (gated by global enable) |
| base_seg_o | output | 3 | Base segment, fixed at 3'b010 |
| tseg_sz_o | output | 2 | Segment size field |
| tseg_en_o | output | 1 | Segment enable |
| ext_top_o | output | 8 | Extended top of the window |

## Verification
Two cases can land on one clock edge. In the first, a single write sets both the lock bit and the open bit. In the second, a read and a write go to the same offset together. The bench covers both with one transaction: a read request and a write of 8'h50 to offset 61h on the same edge, made while open is already 1. It then expects the read data to show the old value 8'h42. A following read must show 8'h12, with open_o at 0 and lock_o at 1, and later writes are checked to bounce off the frozen fields.

// File: rtl/smram_pkg.sv
package smram_pkg;

  // control byte bit positions (neighbours decode these)
  localparam int unsigned CTL_OPEN_B  = 6;
  localparam int unsigned CTL_CLS_B   = 5;
  localparam int unsigned CTL_LOCK_B  = 4;

  // extended byte bit positions
  localparam int unsigned EXT_HIGH_B  = 7;
  localparam int unsigned EXT_MONO_B  = 6;
  localparam int unsigned EXT_GLOB_B  = 3;
  localparam int unsigned EXT_TSZ_LO  = 1;
  localparam int unsigned EXT_TEN_B   = 0;

  typedef struct packed {
    logic       open;
    logic       closed;
    logic       lock;
  } ctl_bits_t;

  typedef struct packed {
    logic       high;
    logic       mono;
    logic       glob;
    logic [1:0] tsz;
    logic       ten;
  } ext_bits_t;

  function automatic logic [7:0] pack_ctl(input ctl_bits_t c, input logic [2:0] base);
    logic [7:0] b;
    b = 8'h00;
    b[CTL_OPEN_B] = c.open;
    b[CTL_CLS_B]  = c.closed;
    b[CTL_LOCK_B] = c.lock;
    b[2:0]        = base;
    return b;
  endfunction

  function automatic logic [7:0] pack_ext(input ext_bits_t e);
    logic [7:0] b;
    b = 8'h00;
    b[EXT_HIGH_B] = e.high;
    b[EXT_MONO_B] = e.mono;
    b[EXT_GLOB_B] = e.glob;
    b[EXT_TSZ_LO +: 2] = e.tsz;
    b[EXT_TEN_B]  = e.ten;
    return b;
  endfunction

endpackage

// File: rtl/smram_ctl_byte.sv
module smram_ctl_byte
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [7:0] wdata,
  output ctl_bits_t  ctl_q,
  output logic       lock_set
);

  logic want_open;
  logic want_lock;

  assign want_open = wdata[CTL_OPEN_B];
  assign want_lock = wdata[CTL_LOCK_B];
  // event: this write takes the lock from 0 to 1
  assign lock_set  = wr_hit && want_lock && !ctl_q.lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_hit) begin
      ctl_q.closed <= wdata[CTL_CLS_B];
      if (lock_set) begin
        ctl_q.lock <= 1'b1;
        ctl_q.open <= 1'b0;
      end else if (!ctl_q.lock) begin
        ctl_q.open <= want_open;
      end
    end
  end

  // R5: the locking write leaves open cleared
  p_open_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set |=> (ctl_q.lock && !ctl_q.open));

  // R7: lock never falls outside reset
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.lock |=> ctl_q.lock);

  // R6: open cannot rise while locked
  p_open_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.lock |=> !ctl_q.open);

endmodule

// File: rtl/smram_ext_regs.sv
module smram_ext_regs
  import smram_pkg::*;
#(
  parameter int unsigned TOP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_hit,
  input  logic             top_hit,
  input  logic             lock_i,
  input  logic [7:0]       wdata,
  output ext_bits_t        ext_q,
  output logic [TOP_W-1:0] top_q,
  output logic             frozen_wr
);

  // event: a write reaches a field group that the lock holds
  assign frozen_wr = (ext_hit || top_hit) && lock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '0;
      top_q <= '0;
    end else begin
      if (ext_hit) begin
        ext_q.mono <= wdata[EXT_MONO_B];
        ext_q.glob <= wdata[EXT_GLOB_B];
        if (!lock_i) begin
          ext_q.high <= wdata[EXT_HIGH_B];
          ext_q.tsz  <= wdata[EXT_TSZ_LO +: 2];
          ext_q.ten  <= wdata[EXT_TEN_B];
        end
      end
      if (top_hit && !lock_i) begin
        top_q <= wdata[TOP_W-1:0];
      end
    end
  end

  // R6: frozen group holds while locked
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> ($stable(ext_q.high) && $stable(ext_q.tsz) &&
                $stable(ext_q.ten) && $stable(top_q)));

endmodule

// File: rtl/smram_rd_port.sv
module smram_rd_port #(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] CTL_OFF = 8'h61,
  parameter logic [ADDR_W-1:0] EXT_OFF = 8'h62,
  parameter logic [ADDR_W-1:0] TOP_OFF = 8'h63,
  parameter logic [2:0] BASE_SEG = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [7:0]        ctl_byte,
  input  logic [7:0]        ext_byte,
  input  logic [7:0]        top_byte,
  output logic [7:0]        rdata_q,
  output logic              rvalid_q
);

  logic [7:0] sel_byte;
  logic       was_ctl_q;

  always_comb begin
    sel_byte = 8'h00;
    if (off_i == CTL_OFF)      sel_byte = ctl_byte;
    else if (off_i == EXT_OFF) sel_byte = ext_byte;
    else if (off_i == TOP_OFF) sel_byte = top_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q   <= 8'h00;
      rvalid_q  <= 1'b0;
      was_ctl_q <= 1'b0;
    end else begin
      rvalid_q  <= rd_i;
      rdata_q   <= rd_i ? sel_byte : 8'h00;
      was_ctl_q <= rd_i && (off_i == CTL_OFF);
    end
  end

  // R8: one-cycle read latency
  p_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rvalid_q);

  // R8: idle bus reads zero
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (!rvalid_q && rdata_q == 8'h00));

  // R2: base segment visible on every control-byte read
  p_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_q && was_ctl_q) |-> (rdata_q[2:0] == BASE_SEG));

endmodule

// File: rtl/smram_ctl_regs.sv
module smram_ctl_regs
  import smram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] CTL_OFF = 8'h61,
  parameter logic [ADDR_W-1:0] EXT_OFF = 8'h62,
  parameter logic [ADDR_W-1:0] TOP_OFF = 8'h63,
  parameter logic [2:0] BASE_SEG = 3'b010
) (
  input  logic              clk,
  input  logic              full_rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_off,
  input  logic              cfg_be,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              cfg_rvalid,
  output logic              open_o,
  output logic              closed_o,
  output logic              lock_o,
  output logic              glob_en_o,
  output logic              high_en_o,
  output logic [2:0]        base_seg_o,
  output logic [1:0]        tseg_sz_o,
  output logic              tseg_en_o,
  output logic [7:0]        ext_top_o
);

  localparam int unsigned TOP_W = 8;

  logic      wr_ok;
  logic      ctl_hit, ext_hit, top_hit;
  ctl_bits_t ctl_q;
  ext_bits_t ext_q;
  logic [TOP_W-1:0] top_q;
  logic      lock_set;
  logic      frozen_wr;

  assign wr_ok   = cfg_wr && cfg_be;
  assign ctl_hit = wr_ok && (cfg_off == CTL_OFF);
  assign ext_hit = wr_ok && (cfg_off == EXT_OFF);
  assign top_hit = wr_ok && (cfg_off == TOP_OFF);

  smram_ctl_byte u_ctl (
    .clk      (clk),
    .rst_n    (full_rst_n),
    .wr_hit   (ctl_hit),
    .wdata    (cfg_wdata),
    .ctl_q    (ctl_q),
    .lock_set (lock_set)
  );

  smram_ext_regs #(.TOP_W(TOP_W)) u_ext (
    .clk       (clk),
    .rst_n     (full_rst_n),
    .ext_hit   (ext_hit),
    .top_hit   (top_hit),
    .lock_i    (ctl_q.lock),
    .wdata     (cfg_wdata),
    .ext_q     (ext_q),
    .top_q     (top_q),
    .frozen_wr (frozen_wr)
  );

  smram_rd_port #(
    .ADDR_W   (ADDR_W),
    .CTL_OFF  (CTL_OFF),
    .EXT_OFF  (EXT_OFF),
    .TOP_OFF  (TOP_OFF),
    .BASE_SEG (BASE_SEG)
  ) u_rd (
    .clk      (clk),
    .rst_n    (full_rst_n),
    .rd_i     (cfg_rd),
    .off_i    (cfg_off),
    .ctl_byte (pack_ctl(ctl_q, BASE_SEG)),
    .ext_byte (pack_ext(ext_q)),
    .top_byte (top_q),
    .rdata_q  (cfg_rdata),
    .rvalid_q (cfg_rvalid)
  );

  assign glob_en_o  = ext_q.glob;
  assign open_o     = ext_q.glob && ctl_q.open;
  assign closed_o   = ext_q.glob && ctl_q.closed;
  assign lock_o     = ext_q.glob && ctl_q.lock;
  assign high_en_o  = ext_q.glob && ext_q.high;
  assign base_seg_o = BASE_SEG;
  assign tseg_sz_o  = ext_q.tsz;
  assign tseg_en_o  = ext_q.ten;
  assign ext_top_o  = top_q;

  // R4: nothing active without the global enable
  p_gate_r4: assert property (@(posedge clk) disable iff (!full_rst_n)
    !glob_en_o |-> !(open_o || closed_o || lock_o || high_en_o));

  // R6: a write into the frozen group leaves the top byte unchanged
  p_top_hold_r6: assert property (@(posedge clk) disable iff (!full_rst_n)
    (frozen_wr && top_hit) |=> $stable(ext_top_o));

  // R9: a write without byte enable leaves the extended fields unchanged
  p_be_r9: assert property (@(posedge clk) disable iff (!full_rst_n)
    (cfg_wr && !cfg_be) |=> ($stable(glob_en_o) && $stable(tseg_sz_o) && $stable(ext_top_o)));

endmodule

// File: tb/test_smram_ctl_regs.sv
module test_smram_ctl_regs;

  logic       clk = 1'b0;
  logic       full_rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_be = 1'b0;
  logic [7:0] cfg_off = 8'h00, cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       cfg_rvalid;
  logic       open_o, closed_o, lock_o, glob_en_o, high_en_o;
  logic [2:0] base_seg_o;
  logic [1:0] tseg_sz_o;
  logic       tseg_en_o;
  logic [7:0] ext_top_o;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  smram_ctl_regs i_smram_ctl_regs (
    .clk(clk), .full_rst_n(full_rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_off(cfg_off), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .open_o(open_o), .closed_o(closed_o), .lock_o(lock_o),
    .glob_en_o(glob_en_o), .high_en_o(high_en_o), .base_seg_o(base_seg_o),
    .tseg_sz_o(tseg_sz_o), .tseg_en_o(tseg_en_o), .ext_top_o(ext_top_o)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [7:0] d, input logic be = 1'b1);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_be = be; cfg_off = off; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] off, input logic [7:0] exp);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_off = off;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk({req, " rvalid"}, {7'd0, cfg_rvalid}, 8'h01);
    chk(req, cfg_rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    full_rst_n = 1'b0;
    @(negedge clk);
    full_rst_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 outputs", {3'd0, open_o, closed_o, lock_o, glob_en_o, high_en_o}, 8'h00);
    chk("R1 base", {5'd0, base_seg_o}, 8'h02);
    rd_chk("R1 ctl", 8'h61, 8'h02);
    rd_chk("R1 ext", 8'h62, 8'h00);
    rd_chk("R1 top", 8'h63, 8'h00);
  endtask

  task automatic t_ctl_fields();
    wr(8'h61, 8'hAD);
    rd_chk("R2 reserved/base ignore", 8'h61, 8'h22);
    chk("R4 closed gated", {7'd0, closed_o}, 8'h00);
    wr(8'h62, 8'h08);
    chk("R4 closed enabled", {7'd0, closed_o}, 8'h01);
    wr(8'h61, 8'h40);
    rd_chk("R2 open", 8'h61, 8'h42);
    chk("R4 open out", {6'd0, open_o, closed_o}, 8'h02);
  endtask

  task automatic t_ext_fields();
    wr(8'h62, 8'hFF);
    rd_chk("R3 ext layout", 8'h62, 8'hCF);
    chk("R3 tseg outs", {5'd0, high_en_o, tseg_sz_o}, 8'h07);
    chk("R3 tseg en", {7'd0, tseg_en_o}, 8'h01);
    wr(8'h63, 8'h5A);
    rd_chk("R3 top", 8'h63, 8'h5A);
    chk("R3 top out", ext_top_o, 8'h5A);
  endtask

  task automatic t_gating();
    wr(8'h62, 8'hC0);
    chk("R4 gated off", {4'd0, open_o, closed_o, lock_o, high_en_o}, 8'h00);
    rd_chk("R4 stored open kept", 8'h61, 8'h42);
  endtask

  task automatic t_be_and_unmapped();
    wr(8'h62, 8'h00, 1'b0);
    rd_chk("R9 be low ignored", 8'h62, 8'hC0);
    rd_chk("R8 unmapped", 8'h60, 8'h00);
  endtask

  task automatic t_read_with_write(input string req, input logic [7:0] off,
                                   input logic [7:0] d, input logic [7:0] exp_old);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_wr = 1'b1; cfg_be = 1'b1; cfg_off = off; cfg_wdata = d;
    @(negedge clk);
    cfg_rd = 1'b0; cfg_wr = 1'b0; cfg_be = 1'b0;
    chk(req, cfg_rdata, exp_old);
  endtask

  task automatic t_collide();
    wr(8'h62, 8'h88);
    t_read_with_write("R8 read sees old ext", 8'h62, 8'h0F, 8'h88);
    rd_chk("R8 new ext", 8'h62, 8'h0F);
    wr(8'h62, 8'h8B);
    rd_chk("R3 ext rewrite", 8'h62, 8'h8B);
  endtask

  task automatic t_lock_open_same();
    t_read_with_write("R8 read sees old ctl", 8'h61, 8'h50, 8'h42);
    rd_chk("R5 lock clears open", 8'h61, 8'h12);
    chk("R5 outs", {6'd0, open_o, lock_o}, 8'h01);
  endtask

  task automatic t_freeze();
    wr(8'h61, 8'h60);
    rd_chk("R6 open frozen closed writable", 8'h61, 8'h32);
    wr(8'h61, 8'h00);
    rd_chk("R7 lock not cleared by write", 8'h61, 8'h12);
    wr(8'h62, 8'h40);
    rd_chk("R6 ext frozen fields", 8'h62, 8'hC3);
    chk("R4 lock gated", {7'd0, lock_o}, 8'h00);
    wr(8'h63, 8'h11);
    rd_chk("R6 top frozen", 8'h63, 8'h5A);
    wr(8'h62, 8'h0F);
    rd_chk("R6 high frozen", 8'h62, 8'h8B);
  endtask

  task automatic t_full_reset();
    do_reset();
    rd_chk("R7 reset clears lock", 8'h61, 8'h02);
    chk("R7 lock out", {7'd0, lock_o}, 8'h00);
    wr(8'h61, 8'h40);
    rd_chk("R7 open writable again", 8'h61, 8'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    full_rst_n = 1'b1;
    t_reset();
    t_ctl_fields();
    t_ext_fields();
    t_gating();
    t_be_and_unmapped();
    t_collide();
    t_lock_open_same();
    t_freeze();
    t_full_reset();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule